// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing register layer of a byte-wide serial port. It sits between a 16-bit register bus (separate write and read strobes with an 8-bit offset) and a transmitter/receiver core, which it reaches only through single-cycle strobes and byte buses. It keeps the outgoing byte, the most recently received byte, a control word with two interrupt enables, and a status word. The status word holds the transmit-empty flag, the receive-ready flag and four receive error flags.

The transmit-empty and receive-ready flags are handled by the data-register accesses themselves. A write of the transmit register empties the flag, and a read of the receive register consumes the byte. The four error flags (break, framing, parity, overrun) are sticky. Hardware sets them and only a software write-1-to-clear removes them. A single level interrupt request combines the gated transmit and receive sources. All outputs, including read data and the interrupt, are registered.

Top module: `sp_reg_front`

## Requirements
- R1: After a synchronous reset, the status word reads 0x0020 (transmit-empty set, everything else clear), the control word reads 0, both data registers read 0, and the interrupt output is 0.
- R2: A write to offset 0x84 stores wdata[7:0] as the outgoing byte, reads back at 0x84 with bits 15-8 as 0, clears transmit-empty (status bit 5) at that same clock edge, and pulses `tx_load` high for exactly the following cycle with the byte on `tx_byte`.
- R3: A `tx_fill` strobe clears transmit-empty and a `tx_free` strobe sets it. When a clearing event (`tx_fill` or a write to 0x84) coincides with `tx_free`, the flag ends up clear.
- R4: `rx_valid` stores `rx_byte` and sets receive-ready (status bit 4). A read of 0x86 returns the stored byte in bits 7-0 and clears receive-ready, unless a new byte arrives in the same cycle, in which case the flag stays set and no overrun is flagged. Writes to 0x86 have no effect.
- R5: `rx_break`, `rx_frame_err` and `rx_parity_err` strobes set status bits 3, 2 and 1 respectively. These flags stay set until software clears them.
- R6: `rx_valid` while receive-ready is 1 and 0x86 is not being read overwrites the stored byte and sets the overrun flag, status bit 0.
- R7: Writing the status word at 0x82 clears each of bits 3-0 that is written as 1. Bits written as 0 are unchanged, and writes to bits 5 and 4 are ignored.
- R8: If a hardware set of an error flag and a software clear of the same flag fall in the same cycle, the flag is set afterwards.
- R9: The control word at 0x80 holds the transmit interrupt enable in bit 0 and the receive interrupt enable in bit 1. Both are writable and read back, and all other bits read 0.
- R10: `irq` equals (bit0 enable AND transmit-empty) OR (bit1 enable AND any error flag), valid in the same cycle the flags and enables take their new values.
- R11: `bus_rdata` is updated one cycle after a read strobe with the value the register held before that edge. It holds its value when there is no read, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_byte | output | 8 | Outgoing byte held for the transmitter |
| tx_load | output | 1 | One-cycle pulse after a new outgoing byte is written |
| tx_fill | input | 1 | Core has taken the byte into its holding buffer |
| tx_free | input | 1 | Core can accept a new byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected strobe |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_parity_err | input | 1 | Parity error strobe |
| irq | output | 1 | Level serial-port interrupt request |

## Verification
The bench targets coincidences. These are a status write clearing a flag in the same cycle that hardware sets it, a receive-register read in the cycle a new byte arrives, and a `tx_free` strobe together with a transmit write or `tx_fill`. A design with the wrong priority would lose an error event, raise a false overrun, or report the transmitter empty while a byte is still pending. It also writes 1s into the read-only bits 5 and 4 and into unmapped control bits, where a careless decoder would corrupt the handshake flags. The interrupt is compared on every cycle, so an interrupt that lags the flags by one cycle or ignores an enable shows up at once.

// File: rtl/sp_regs_pkg.sv
package sp_regs_pkg;
  localparam int unsigned ERR_W     = 4;
  localparam int unsigned STAT_THRE = 5;
  localparam int unsigned STAT_RDR  = 4;
  localparam int unsigned CTRL_TXIE = 0;
  localparam int unsigned CTRL_RXIE = 1;
  localparam int unsigned CTRL_W    = 2;

  // error flag word, bit 3 down to bit 0 as seen in the status register
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } err_flags_t;
endpackage

// File: rtl/sp_tx_hold.sv
module sp_tx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              core_fill,
  input  logic              core_free,
  output logic [BYTE_W-1:0] hold_byte,
  output logic              load_pulse,
  output logic              empty_q,
  output logic              empty_nxt
);
  always_comb begin
    if (wr_en || core_fill) empty_nxt = 1'b0;
    else if (core_free)     empty_nxt = 1'b1;
    else                    empty_nxt = empty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte  <= '0;
      load_pulse <= 1'b0;
      empty_q    <= 1'b1;
    end else begin
      load_pulse <= wr_en;
      empty_q    <= empty_nxt;
      if (wr_en) hold_byte <= wr_byte;
    end
  end

  // R2: a software write empties the flag at the same edge
  p_empty_clr_on_wr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty_q);
  // R2: the load pulse follows the write and carries the written byte
  p_load_byte_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (load_pulse && hold_byte == $past(wr_byte)));
  // R3: clearing wins over a coincident free strobe
  p_clr_beats_free_r3: assert property (@(posedge clk) disable iff (rst)
    (core_fill && core_free) |=> !empty_q);
endmodule

// File: rtl/sp_rx_stat.sv
module sp_rx_stat
  import sp_regs_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rd_data,
  input  logic              clr_wr,
  input  logic [ERR_W-1:0]  clr_mask,
  output logic [BYTE_W-1:0] rx_hold,
  output logic              ready_q,
  output logic [ERR_W-1:0]  err_q,
  output logic [ERR_W-1:0]  err_nxt
);
  err_flags_t set_ev;
  logic       overrun;

  assign overrun = rx_valid && ready_q && !rd_data;

  always_comb begin
    set_ev.brk = rx_break;
    set_ev.frm = rx_frame_err;
    set_ev.par = rx_parity_err;
    set_ev.ovr = overrun;
    err_nxt    = (err_q & ~(clr_wr ? clr_mask : '0)) | set_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      ready_q <= 1'b0;
      err_q   <= '0;
    end else begin
      err_q <= err_nxt;
      if (rx_valid) begin
        rx_hold <= rx_byte;
        ready_q <= 1'b1;
      end else if (rd_data) begin
        ready_q <= 1'b0;
      end
    end
  end

  // R4: a new byte always leaves the ready flag set
  p_ready_on_byte_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> ready_q);
  // R6: a byte on top of an unread byte flags an overrun
  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ready_q && !rd_data) |=> err_q[0]);
  // R5: without a clearing write no flag drops
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R8: a break event survives a coincident clear
  p_set_beats_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_break && clr_wr && clr_mask[3]) |=> err_q[3]);
endmodule

// File: rtl/sp_irq_gen.sv
module sp_irq_gen
  import sp_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en_nxt,
  input  logic             rx_en_nxt,
  input  logic             empty_nxt,
  input  logic [ERR_W-1:0] err_nxt,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (tx_en_nxt && empty_nxt) || (rx_en_nxt && |err_nxt);
  end
endmodule

// File: rtl/sp_reg_front.sv
module sp_reg_front
  import sp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h82,
  parameter logic [ADDR_W-1:0] TXD_OFS  = 8'h84,
  parameter logic [ADDR_W-1:0] RXD_OFS  = 8'h86
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_load,
  input  logic              tx_fill,
  input  logic              tx_free,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  output logic              irq
);
  localparam int unsigned STAT_W = STAT_THRE + 1;

  logic              wr_ctrl, wr_stat, wr_txd, rd_rxd;
  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic              empty_q, empty_nxt, ready_q;
  logic [ERR_W-1:0]  err_q, err_nxt;
  logic [BYTE_W-1:0] rx_hold;
  logic [STAT_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFS);
  assign wr_stat = bus_wr && (bus_addr == STAT_OFS);
  assign wr_txd  = bus_wr && (bus_addr == TXD_OFS);
  assign rd_rxd  = bus_rd && (bus_addr == RXD_OFS);

  assign ctrl_nxt = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

  sp_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_txd),
    .wr_byte   (bus_wdata[BYTE_W-1:0]),
    .core_fill (tx_fill),
    .core_free (tx_free),
    .hold_byte (tx_byte),
    .load_pulse(tx_load),
    .empty_q   (empty_q),
    .empty_nxt (empty_nxt)
  );

  sp_rx_stat #(.BYTE_W(BYTE_W)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .rx_break     (rx_break),
    .rx_frame_err (rx_frame_err),
    .rx_parity_err(rx_parity_err),
    .rd_data      (rd_rxd),
    .clr_wr       (wr_stat),
    .clr_mask     (bus_wdata[ERR_W-1:0]),
    .rx_hold      (rx_hold),
    .ready_q      (ready_q),
    .err_q        (err_q),
    .err_nxt      (err_nxt)
  );

  sp_irq_gen u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_en_nxt(ctrl_nxt[CTRL_TXIE]),
    .rx_en_nxt(ctrl_nxt[CTRL_RXIE]),
    .empty_nxt(empty_nxt),
    .err_nxt  (err_nxt),
    .irq      (irq)
  );

  always_comb begin
    stat_word            = '0;
    stat_word[STAT_THRE] = empty_q;
    stat_word[STAT_RDR]  = ready_q;
    stat_word[ERR_W-1:0] = err_q;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_OFS)      rd_mux[CTRL_W-1:0] = ctrl_q;
    else if (bus_addr == STAT_OFS) rd_mux[STAT_W-1:0] = stat_word;
    else if (bus_addr == TXD_OFS)  rd_mux[BYTE_W-1:0] = tx_byte;
    else if (bus_addr == RXD_OFS)  rd_mux[BYTE_W-1:0] = rx_hold;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R10: an enabled pending error always shows on the request line
  p_irq_rx_src_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTRL_RXIE] && |err_q) |-> irq);
  // R10: with both enables off the request is low
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q == '0) |-> !irq);
  // R11: read data is stable when nothing is read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R7: the read-only flags do not move on a status write alone
  p_ro_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !rx_valid && !rd_rxd && !tx_fill && !tx_free) |=>
      ($stable(ready_q) && $stable(empty_q)));
endmodule

// File: tb/sp_reg_front_bench.sv
`timescale 1ns/1ps
module sp_reg_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_load;
  logic        tx_fill = 0, tx_free = 0;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_break = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sp_reg_front u_sp_reg_front (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_load(tx_load), .tx_fill(tx_fill), .tx_free(tx_free),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .irq(irq)
  );

  // behavioural reference
  bit        m_thre, m_rdr, m_irq, m_load;
  bit [3:0]  m_err;
  bit [1:0]  m_ctl;
  bit [7:0]  m_txd, m_rxd;
  bit [15:0] m_rdata;

  always @(posedge clk) begin
    bit rd86, ovr;
    if (rst) begin
      m_thre = 1; m_rdr = 0; m_err = 0; m_ctl = 0; m_txd = 0; m_rxd = 0;
      m_rdata = 0; m_irq = 0; m_load = 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          8'h80:   m_rdata = {14'd0, m_ctl};
          8'h82:   m_rdata = {10'd0, m_thre, m_rdr, m_err};
          8'h84:   m_rdata = {8'd0, m_txd};
          8'h86:   m_rdata = {8'd0, m_rxd};
          default: m_rdata = 16'd0;
        endcase
      end
      rd86 = bus_rd && bus_addr == 8'h86;
      ovr  = rx_valid && m_rdr && !rd86;
      m_load = bus_wr && bus_addr == 8'h84;
      if (m_load) m_txd = bus_wdata[7:0];
      if (m_load || tx_fill) m_thre = 0;
      else if (tx_free) m_thre = 1;
      if (bus_wr && bus_addr == 8'h82) m_err = m_err & ~bus_wdata[3:0];
      m_err = m_err | {rx_break, rx_frame_err, rx_parity_err, ovr};
      if (rx_valid) begin m_rdr = 1; m_rxd = rx_byte; end
      else if (rd86) m_rdr = 0;
      if (bus_wr && bus_addr == 8'h80) m_ctl = bus_wdata[1:0];
      m_irq = (m_ctl[0] && m_thre) || (m_ctl[1] && (m_err != 0));
    end
    started = 1;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R11 bus_rdata", bus_rdata, m_rdata);
      chk("R10 irq", {15'd0, irq}, {15'd0, m_irq});
      chk("R2 tx_load", {15'd0, tx_load}, {15'd0, m_load});
      chk("R2 tx_byte", {8'd0, tx_byte}, {8'd0, m_txd});
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic rx(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    tick();
    rx_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) tick();
    rst = 0;
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    rd(8'h80, 16'h0000, "R1 control reset");
    rd(8'h82, 16'h0020, "R1 status reset");
    rd(8'h84, 16'h0000, "R1 tx data reset");
    rd(8'h86, 16'h0000, "R1 rx data reset");

    wr(8'h84, 16'hFFA5);
    rd(8'h82, 16'h0000, "R2 empty cleared by write");
    rd(8'h84, 16'h00A5, "R2 tx readback");
    tx_free = 1; tick(); tx_free = 0;
    rd(8'h82, 16'h0020, "R3 free sets empty");
    tx_fill = 1; tick(); tx_fill = 0;
    rd(8'h82, 16'h0000, "R3 fill clears empty");
    tx_free = 1; tx_fill = 1; tick(); tx_free = 0; tx_fill = 0;
    rd(8'h82, 16'h0000, "R3 fill beats free");
    tx_free = 1; bus_wr = 1; bus_addr = 8'h84; bus_wdata = 16'h005A; tick();
    tx_free = 0; bus_wr = 0;
    rd(8'h82, 16'h0000, "R3 write beats free");
    tx_free = 1; tick(); tx_free = 0;

    rx(8'h3C);
    rd(8'h82, 16'h0030, "R4 ready set");
    rd(8'h86, 16'h003C, "R4 rx byte");
    rd(8'h82, 16'h0020, "R4 ready cleared by read");
    wr(8'h86, 16'h00EE);
    rd(8'h86, 16'h003C, "R4 write to rx ignored");

    rx(8'h11); rx(8'h22);
    rd(8'h82, 16'h0031, "R6 overrun flagged");
    rd(8'h86, 16'h0022, "R6 byte overwritten");
    wr(8'h82, 16'h0001);

    rx(8'h44);
    bus_rd = 1; bus_addr = 8'h86; rx_valid = 1; rx_byte = 8'h55; tick();
    bus_rd = 0; rx_valid = 0;
    chk("R4 read during arrival", bus_rdata, 16'h0044);
    rd(8'h82, 16'h0030, "R4 ready kept, no overrun");
    rd(8'h86, 16'h0055, "R4 new byte");

    rx_break = 1; rx_frame_err = 1; rx_parity_err = 1; tick();
    rx_break = 0; rx_frame_err = 0; rx_parity_err = 0;
    repeat (3) tick();
    rd(8'h82, 16'h002E, "R5 error flags sticky");
    wr(8'h82, 16'h0002);
    rd(8'h82, 16'h002C, "R7 w1c parity");
    wr(8'h82, 16'hFFF0);
    rd(8'h82, 16'h002C, "R7 bits 5,4 and zeros ignored");

    rx_parity_err = 1; bus_wr = 1; bus_addr = 8'h82; bus_wdata = 16'h000F; tick();
    rx_parity_err = 0; bus_wr = 0;
    rd(8'h82, 16'h0022, "R8 set beats clear");

    wr(8'h80, 16'hFFFF);
    rd(8'h80, 16'h0003, "R9 control readback");
    chk("R10 irq both enabled", {15'd0, irq}, 16'd1);
    wr(8'h82, 16'h000F);
    wr(8'h80, 16'h0002);
    chk("R10 irq rx enable no errors", {15'd0, irq}, 16'd0);
    rx_break = 1; tick(); rx_break = 0;
    chk("R10 irq on break", {15'd0, irq}, 16'd1);
    wr(8'h80, 16'h0001);
    chk("R10 irq tx empty", {15'd0, irq}, 16'd1);
    wr(8'h84, 16'h0001);
    chk("R10 irq drops with write", {15'd0, irq}, 16'd0);
    rd(8'h90, 16'h0000, "R11 unmapped read");

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 4);
      bus_addr  = (r == 4) ? 8'h90 : 8'h80 + 8'(r * 2);
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_rd    = ($urandom_range(0, 2) == 0);
      bus_wdata = 16'($urandom);
      tx_fill   = ($urandom_range(0, 5) == 0);
      tx_free   = ($urandom_range(0, 3) == 0);
      rx_valid  = ($urandom_range(0, 3) == 0);
      rx_byte   = 8'($urandom);
      rx_break      = ($urandom_range(0, 15) == 0);
      rx_frame_err  = ($urandom_range(0, 15) == 0);
      rx_parity_err = ($urandom_range(0, 15) == 0);
      tick();
    end
    bus_wr = 0; bus_rd = 0; tx_fill = 0; tx_free = 0; rx_valid = 0;
    rx_break = 0; rx_frame_err = 0; rx_parity_err = 0;
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule